// File: doc/BRIEF.md
# Interrupt Level Acceptance Gate

This block decides when a pending interrupt priority level is accepted by a processor core, measured against instruction boundaries. It takes a 3-bit active-low level input and converts it to a positive level. It synchronises that level through a flip-flop chain. Once per instruction, on a latch-point strobe from the core's sequencer, it captures the synchronised level. At each end-of-instruction strobe it compares the captured level with the status-register mask and raises a one-cycle take request that carries the accepted level.

The capture point comes before the end of the instruction. A level that rises after the current instruction's capture point is therefore seen only at the next capture point, and is taken one instruction later. A level that was captured earlier but held back by the mask stays captured. It is taken at the end of whichever instruction lowers the mask far enough, with no added instruction of latency. The core's sequencer places the latch-point strobe. For instructions with memory operands it comes after the last operand read, otherwise on the first step. For a long-word move it comes at the start of the second write. The gate treats all levels alike.

Top module: `irq_gate`

## Requirements
- R1: After reset, take_o is 0 and take_lvl_o is 0.
- R2: A level that rises on the input after the capture point of an instruction is not taken at the end of that instruction.
- R3: A captured level is taken at the end of the instruction: take_o pulses high for one cycle, starting the cycle after instr_end_i is high. take_lvl_o shows the accepted level and holds it until the next take.
- R4: A captured level at or below the mask is not taken. If the mask later drops below it, the level is taken at the end of that instruction with no new capture needed.
- R5: Level 7 is taken even when the mask is 7.
- R6: A level equal to the mask is not taken. Only a level strictly greater than the mask, or level 7, is accepted.
- R7: After a take, no further take happens until a new capture point has sampled a nonzero level.
- R8: The input passes through two synchronising flip-flops. A change driven less than two clock cycles before a capture strobe is not captured by that strobe.
- R9: A level that drops after it was captured is still taken at the end of that instruction.
- R10: When latch_pt_i and instr_end_i are high in the same cycle, the decision uses the previously captured level, and the newly captured level remains pending.
- R11: A capture of level 0 replaces any pending level, so nothing is taken afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ipl_ni | input | 3 | Interrupt priority level, active low |
| latch_pt_i | input | 1 | Capture strobe, one per instruction |
| instr_end_i | input | 1 | End-of-instruction strobe |
| mask_i | input | 3 | Status register interrupt mask |
| take_o | output | 1 | Interrupt accepted, one-cycle pulse |
| take_lvl_o | output | 3 | Accepted level |

## Verification
The bench raises a level just after a capture point and expects the take one instruction later. A gate that compared the live input, instead of the captured level, would take it one instruction early.

It parks a level behind the mask and then lowers the mask. A design that demanded a fresh capture would add an instruction of delay.

It also covers several other edges:
- A level equal to the mask must not be taken. An off-by-one compare would take it.
- Level 7 must be taken at mask 7. Plain masking would block it.
- A repeated end strobe must not retake a level. A take that left the pending flag set would retake it.
- A capture and an end strobe in the same cycle must decide on the old level. Decision logic that saw the new level would take the wrong one.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned IPL_W = 3;
  localparam int unsigned SYNC_DEPTH = 2;

  function automatic logic lvl_wins(input logic [IPL_W-1:0] lvl,
                                    input logic [IPL_W-1:0] mask);
    return (lvl > mask) || (&lvl);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         latch_pt_i,
  input  logic [W-1:0] lvl_i,
  input  logic         taken_i,
  output logic         pend_o,
  output logic [W-1:0] lvl_o
);
  logic         pend_q;
  logic [W-1:0] lvl_q;

  // a fresh capture overrides the clear from a same-cycle take
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lvl_q  <= '0;
    end else if (latch_pt_i) begin
      pend_q <= |lvl_i;
      lvl_q  <= lvl_i;
    end else if (taken_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/irq_decide.sv
module irq_decide
  import irq_gate_pkg::*;
#(
  parameter int unsigned W = IPL_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         instr_end_i,
  input  logic         pend_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o,
  output logic         take_o,
  output logic [W-1:0] take_lvl_o
);
  logic         take_q;
  logic [W-1:0] take_lvl_q;
  logic         above;

  always_comb begin
    above = (lvl_i > mask_i) || (&lvl_i);
    hit_o = instr_end_i && pend_i && above;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q     <= 1'b0;
      take_lvl_q <= '0;
    end else begin
      take_q <= hit_o;
      if (hit_o) take_lvl_q <= lvl_i;
    end
  end

  assign take_o     = take_q;
  assign take_lvl_o = take_lvl_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned LVL_W  = IPL_W,
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] ipl_ni,
  input  logic             latch_pt_i,
  input  logic             instr_end_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic             take_o,
  output logic [LVL_W-1:0] take_lvl_o
);
  logic [LVL_W-1:0] lvl_raw, lvl_sync, lvl_held;
  logic             pend, hit;

  assign lvl_raw = ~ipl_ni;

  irq_sync #(.W(LVL_W), .STAGES(STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lvl_raw),
    .q_o   (lvl_sync)
  );

  irq_latch #(.W(LVL_W)) i_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .latch_pt_i(latch_pt_i),
    .lvl_i     (lvl_sync),
    .taken_i   (hit),
    .pend_o    (pend),
    .lvl_o     (lvl_held)
  );

  irq_decide #(.W(LVL_W)) i_decide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .instr_end_i(instr_end_i),
    .pend_i     (pend),
    .lvl_i      (lvl_held),
    .mask_i     (mask_i),
    .hit_o      (hit),
    .take_o     (take_o),
    .take_lvl_o (take_lvl_o)
  );
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int unsigned LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_end_i,
  input logic [LVL_W-1:0] mask_i,
  input logic             take_o,
  input logic [LVL_W-1:0] take_lvl_o
);
  a_r3_take_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(instr_end_i));

  a_r3_lvl_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable(take_lvl_o));

  a_r6_above_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((take_lvl_o > $past(mask_i)) || (&take_lvl_o)));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  a_r11_lvl_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (take_lvl_o != '0));
endmodule

bind irq_gate irq_gate_chk #(.LVL_W(LVL_W)) i_irq_gate_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .instr_end_i(instr_end_i),
  .mask_i     (mask_i),
  .take_o     (take_o),
  .take_lvl_o (take_lvl_o)
);

// File: tb/test_irq_gate.sv
module test_irq_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] ipl_ni = 3'b111;
  logic       latch_pt_i = 1'b0;
  logic       instr_end_i = 1'b0;
  logic [2:0] mask_i = 3'd0;
  logic       take_o;
  logic [2:0] take_lvl_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  irq_gate i_irq_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ipl_ni     (ipl_ni),
    .latch_pt_i (latch_pt_i),
    .instr_end_i(instr_end_i),
    .mask_i     (mask_i),
    .take_o     (take_o),
    .take_lvl_o (take_lvl_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_lvl(input int l);
    ipl_ni = ~l[2:0];
    repeat (3) @(negedge clk_i);
  endtask

  task automatic latch_pt();
    latch_pt_i = 1'b1;
    @(negedge clk_i);
    latch_pt_i = 1'b0;
  endtask

  task automatic end_instr(output int t, output int l);
    instr_end_i = 1'b1;
    @(negedge clk_i);
    instr_end_i = 1'b0;
    t = int'(take_o);
    l = int'(take_lvl_o);
    @(negedge clk_i);
  endtask

  task automatic flush();
    int t, l;
    set_lvl(0);
    mask_i = 3'd7;
    latch_pt();
    end_instr(t, l);
  endtask

  task automatic t_reset();
    check("R1 take", int'(take_o), 0);
    check("R1 lvl", int'(take_lvl_o), 0);
  endtask

  task automatic t_latency();
    int t, l;
    mask_i = 3'd0;
    latch_pt();
    set_lvl(3);
    end_instr(t, l);
    check("R2 no take same instr", t, 0);
    latch_pt();
    end_instr(t, l);
    check("R3 take next instr", t, 1);
    check("R3 level", l, 3);
    @(negedge clk_i);
    check("R3 pulse one cycle", int'(take_o), 0);
    check("R3 level held", int'(take_lvl_o), 3);
    flush();
  endtask

  task automatic t_mask_release();
    int t, l;
    mask_i = 3'd5;
    set_lvl(4);
    latch_pt();
    end_instr(t, l);
    check("R4 masked", t, 0);
    mask_i = 3'd2;
    end_instr(t, l);
    check("R4 unmask take", t, 1);
    check("R4 level", l, 4);
    flush();
  endtask

  task automatic t_nmi();
    int t, l;
    mask_i = 3'd7;
    set_lvl(7);
    latch_pt();
    end_instr(t, l);
    check("R5 level 7 unmaskable", t, 1);
    check("R5 level", l, 7);
    flush();
  endtask

  task automatic t_equal();
    int t, l;
    mask_i = 3'd4;
    set_lvl(4);
    latch_pt();
    end_instr(t, l);
    check("R6 equal not taken", t, 0);
    mask_i = 3'd3;
    end_instr(t, l);
    check("R6 above taken", t, 1);
    flush();
  endtask

  task automatic t_relatch();
    int t, l;
    mask_i = 3'd0;
    set_lvl(2);
    latch_pt();
    end_instr(t, l);
    check("R7 first take", t, 1);
    end_instr(t, l);
    check("R7 no retake", t, 0);
    latch_pt();
    end_instr(t, l);
    check("R7 take after relatch", t, 1);
    flush();
  endtask

  task automatic t_sync();
    int t, l;
    mask_i = 3'd0;
    ipl_ni = ~3'd6;
    latch_pt();
    end_instr(t, l);
    check("R8 late change missed", t, 0);
    repeat (2) @(negedge clk_i);
    latch_pt();
    end_instr(t, l);
    check("R8 taken next instr", t, 1);
    check("R8 level", l, 6);
    flush();
  endtask

  task automatic t_drop();
    int t, l;
    mask_i = 3'd1;
    set_lvl(5);
    latch_pt();
    set_lvl(0);
    end_instr(t, l);
    check("R9 dropped level taken", t, 1);
    check("R9 level", l, 5);
    flush();
  endtask

  task automatic t_same_cycle();
    int t, l;
    mask_i = 3'd0;
    set_lvl(3);
    latch_pt();
    set_lvl(5);
    latch_pt_i = 1'b1;
    end_instr(t, l);
    latch_pt_i = 1'b0;
    check("R10 old level decides", l, 3);
    check("R10 take", t, 1);
    end_instr(t, l);
    check("R10 new level pending", l, 5);
    flush();
  endtask

  task automatic t_zero_capture();
    int t, l;
    mask_i = 3'd5;
    set_lvl(3);
    latch_pt();
    end_instr(t, l);
    set_lvl(0);
    latch_pt();
    mask_i = 3'd0;
    end_instr(t, l);
    check("R11 zero capture clears", t, 0);
    flush();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_latency();
    t_mask_release();
    t_nmi();
    t_equal();
    t_relatch();
    t_sync();
    t_drop();
    t_same_cycle();
    t_zero_capture();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule